// File: doc/BRIEF.md
# NAND Page Hamming Parity Generator

This block builds a 24-bit row/column Hamming parity code over one 512-byte NAND page while the page streams past it, one byte per strobe, in either direction of transfer. Twelve parity terms are kept. Three are column terms, taken over the bit position inside each byte. Nine are row terms, taken over the byte position inside the page. Each term is held as a complementary pair of bits. The controller places the code in the spare area and later compares it against a freshly computed one. That comparison and any correction happen outside this block.

The stream is armed by raising `ecc_en`. While it is high, every strobed byte is folded into the accumulator, up to the end of the page. After the 512th byte, `done` rises and the code holds still. Dropping `ecc_en` clears the accumulator and byte position, and raising it again starts a new page. The code is presented inverted, so a page of erased (all-ones) bytes, or a page not yet started, reads as 0xFFFFFF.

Top module: `pgecc_gen`

## Requirements
- R1: After a cycle with `rst_n` low, `code_out` is 24'hFFFFFF and `done` is 0.
- R2: Parity term k (k = 0..11) occupies `code_out` bits 2k+1 and 2k. Bit 2k+1 covers the data bits whose selecting index bit is 1, and bit 2k covers those whose selecting index bit is 0. Terms 0..2 therefore fill byte 0 from its LSB, with term 3 in its top pair. Bytes 1 and 2 hold terms 4..7 and 8..11.
- R3: For terms 0..2, the selecting index is the bit position (0..7) inside each byte, and bit k of that position selects.
- R4: For terms 3..11, the selecting index is the byte position (0..511) in the page, counted from 0 at arming, and bit k-3 of that position selects.
- R5: Each output bit is the inverse of the XOR of its covered data bits, taken over the bytes absorbed so far. A full page of 0xFF, and a full page of 0x00, both give 24'hFFFFFF.
- R6: A byte is absorbed only on a rising clock edge where `ecc_en` and `din_valid` are both 1 and `done` is 0. Cycles with `din_valid` low leave `code_out` and the byte position unchanged.
- R7: `done` rises in the cycle after the 512th byte is absorbed and not earlier. It stays high while `ecc_en` stays high.
- R8: While `done` is high, further strobed bytes are ignored and `code_out` holds its value.
- R9: On the edge after a cycle with `ecc_en` low, the code returns to 24'hFFFFFF and `done` to 0. Strobed bytes are ignored while `ecc_en` is low. On re-arming, the next absorbed byte is byte position 0 of a new page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| ecc_en | input | 1 | Arms accumulation when high; clears the page state when low |
| din_valid | input | 1 | Strobe marking `din` as a page byte this cycle |
| din | input | 8 | Page data byte |
| done | output | 1 | High once a whole page has been absorbed |
| code_out | output | 24 | Inverted parity code; byte 0 in bits 7:0 |

## Verification
A wrong byte-position count shows up within one absorbed byte as the wrong row pair flipping. It also moves the `done` edge away from the cycle after byte 512. A bad column mask or pair order shows up as a wrong pair in byte 0 on the first byte that has a single bit set. Sweeping one set bit over every bit position, at byte positions that light each row index bit, isolates every pair. Clearing faults appear on the first code read after `ecc_en` drops. Absorption past the page end appears on the first byte strobed after `done`.

// File: rtl/pgecc_pkg.sv
// Shared sizing for the page parity generator.
// Assumes a byte-serial stream, with widths derived from byte and page size.
package pgecc_pkg;
    localparam int unsigned BYTE_BITS  = 8;
    localparam int unsigned PAGE_SIZE  = 512;

    // Number of pair terms needed to index 'n' positions.
    function automatic int unsigned terms_for(input int unsigned n);
        return $clog2(n);
    endfunction
endpackage

// File: rtl/pgecc_terms.sv
// Per-byte parity contribution.
// Given one byte and its position in the page, it produces the 2*TERMS-bit
// vector that this byte XORs into the running code. Purely combinational.
// Assumes BYTE_W is a power of two.
module pgecc_terms #(
    parameter int unsigned BYTE_W = pgecc_pkg::BYTE_BITS,
    parameter int unsigned IDX_W  = 9,
    localparam int unsigned COL_T = pgecc_pkg::terms_for(BYTE_W),
    localparam int unsigned ALL_T = COL_T + IDX_W
) (
    input  logic [BYTE_W-1:0]  data,
    input  logic [IDX_W-1:0]   idx,
    output logic [2*ALL_T-1:0] contrib
);
    logic byte_par;

    // Whole-byte parity feeds every row pair.
    assign byte_par = ^data;

    // Column pairs: split the byte by one bit of the bit position.
    for (genvar k = 0; k < COL_T; k++) begin : g_col
        logic [BYTE_W-1:0] sel_hi;
        for (genvar b = 0; b < BYTE_W; b++) begin : g_mask
            assign sel_hi[b] = ((b >> k) & 1) != 0;
        end
        assign contrib[2*k+1] = ^(data & sel_hi);
        assign contrib[2*k]   = ^(data & ~sel_hi);
    end

    // Row pairs: route the byte parity by one bit of the byte position.
    for (genvar j = 0; j < IDX_W; j++) begin : g_row
        assign contrib[2*(COL_T+j)+1] = idx[j] & byte_par;
        assign contrib[2*(COL_T+j)]   = ~idx[j] & byte_par;
    end
endmodule

// File: rtl/pgecc_count.sv
// Byte position tracker.
// Tracks the next byte position, qualifies strobes into absorb pulses and
// flags a full page. A low 'arm' restarts the page.
module pgecc_count #(
    parameter int unsigned PAGE_BYTES = pgecc_pkg::PAGE_SIZE,
    localparam int unsigned IDX_W = pgecc_pkg::terms_for(PAGE_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             strobe,
    output logic [IDX_W-1:0] idx,
    output logic             take,
    output logic             full
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(PAGE_BYTES - 1);

    // A byte is absorbed only while armed and the page is not yet full.
    assign take = arm & strobe & ~full;

    // Advance the position per absorbed byte; mark full on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm) begin
            idx  <= '0;
            full <= 1'b0;
        end else if (take) begin
            if (idx == LAST) begin
                idx  <= '0;
                full <= 1'b1;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pgecc_accum.sv
// Parity accumulator.
// Holds the raw (uninverted) code. Each absorbed byte's contribution is
// XORed in, and the register is cleared whenever not armed.
module pgecc_accum #(
    parameter int unsigned W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         arm,
    input  logic         take,
    input  logic [W-1:0] contrib,
    output logic [W-1:0] raw
);
    // Clear on reset or disarm; otherwise fold in absorbed bytes.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm)
            raw <= '0;
        else if (take)
            raw <= raw ^ contrib;
    end
endmodule

// File: rtl/pgecc_gen.sv
// NAND page row/column parity generator, top level.
// Absorbs up to PAGE_BYTES strobed bytes while ecc_en is high and presents
// the inverted paired parity code. Assumes a power-of-two page size.
module pgecc_gen #(
    parameter int unsigned BYTE_W     = pgecc_pkg::BYTE_BITS,
    parameter int unsigned PAGE_BYTES = pgecc_pkg::PAGE_SIZE,
    localparam int unsigned IDX_W  = pgecc_pkg::terms_for(PAGE_BYTES),
    localparam int unsigned CODE_W = 2 * (pgecc_pkg::terms_for(BYTE_W) + IDX_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ecc_en,
    input  logic              din_valid,
    input  logic [BYTE_W-1:0] din,
    output logic              done,
    output logic [CODE_W-1:0] code_out
);
    logic [IDX_W-1:0]  pos;
    logic              take;
    logic [CODE_W-1:0] contrib;
    logic [CODE_W-1:0] raw;

    pgecc_count #(.PAGE_BYTES(PAGE_BYTES)) u_count (
        .clk(clk), .rst_n(rst_n), .arm(ecc_en), .strobe(din_valid),
        .idx(pos), .take(take), .full(done)
    );

    pgecc_terms #(.BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_terms (
        .data(din), .idx(pos), .contrib(contrib)
    );

    pgecc_accum #(.W(CODE_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .arm(ecc_en), .take(take),
        .contrib(contrib), .raw(raw)
    );

    // Inverted so that erased data reads as all ones.
    assign code_out = ~raw;
endmodule

// File: rtl/pgecc_gen_chk.sv
// Port-level properties of the page parity generator, bound to the top.
module pgecc_gen_chk #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned CODE_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ecc_en,
    input logic              din_valid,
    input logic [BYTE_W-1:0] din,
    input logic              done,
    input logic [CODE_W-1:0] code_out
);
    localparam logic [CODE_W-1:0] ONES = '1;

    AST_RESET_STATE: assert property (@(posedge clk) !rst_n |=> (code_out == ONES && !done)); // R1
    AST_ODD_BYTE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_en && din_valid && !done && ^din) |=> $countones(code_out ^ $past(code_out)) == CODE_W/2); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_en && !din_valid) |=> $stable(code_out)); // R6
    AST_DONE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ecc_en) |=> done); // R7
    AST_FULL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ecc_en) |=> $stable(code_out)); // R8
    AST_DISARM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !ecc_en |=> (code_out == ONES && !done)); // R9
endmodule

bind pgecc_gen pgecc_gen_chk #(.BYTE_W(BYTE_W), .CODE_W(CODE_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .ecc_en(ecc_en), .din_valid(din_valid),
    .din(din), .done(done), .code_out(code_out)
);

// File: tb/test_pgecc_gen.sv
`timescale 1ns/1ps
module test_pgecc_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ecc_en = 1'b0;
    logic        din_valid = 1'b0;
    logic [7:0]  din = 8'h00;
    logic        done;
    logic [23:0] code_out;

    int checks = 0;
    int errors = 0;
    logic [7:0] page [512];
    logic [15:0] lfsr = 16'hACE1;

    pgecc_gen i_pgecc_gen (
        .clk(clk), .rst_n(rst_n), .ecc_en(ecc_en), .din_valid(din_valid),
        .din(din), .done(done), .code_out(code_out)
    );

    always #2.5 clk = ~clk;

    // Reference: walk every set bit, toggle the pair side chosen by each index bit.
    function automatic logic [23:0] model(input int n);
        logic [23:0] r = '0;
        for (int i = 0; i < n; i++)
            for (int b = 0; b < 8; b++)
                if (page[i][b]) begin
                    for (int k = 0; k < 3; k++)
                        r[2*k + ((b >> k) & 1)] ^= 1'b1;
                    for (int j = 0; j < 9; j++)
                        r[2*(3+j) + ((i >> j) & 1)] ^= 1'b1;
                end
        return ~r;
    endfunction

    task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %06h expected %06h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        din_valid = 1'b1;
        din = b;
    endtask

    task automatic idle();
        @(negedge clk);
        din_valid = 1'b0;
        din = 8'h5A;
    endtask

    task automatic rearm();
        @(negedge clk); din_valid = 1'b0; ecc_en = 1'b0;
        @(negedge clk); ecc_en = 1'b1;
    endtask

    // Feed n bytes of page[], with optional idle gaps, then settle.
    task automatic feed(input int n, input bit gaps);
        for (int i = 0; i < n; i++) begin
            push(page[i]);
            if (gaps && (i % 7 == 3)) idle();
        end
        idle();
    endtask

    function automatic logic [7:0] rnd();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[7:0];
    endfunction

    initial begin
        #1_000_000;
        errors++; checks++;
        $display("FAIL watchdog actual hung expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset code", code_out, 24'hFFFFFF);
        chk("R1 reset done", {23'b0, done}, 24'h0);
        rst_n = 1'b1;
        ecc_en = 1'b1;

        // R5: erased and zero pages
        for (int i = 0; i < 512; i++) page[i] = 8'hFF;
        feed(512, 1'b0);
        chk("R5 erased page", code_out, 24'hFFFFFF);
        rearm();
        for (int i = 0; i < 512; i++) page[i] = 8'h00;
        feed(512, 1'b0);
        chk("R5 zero page", code_out, 24'hFFFFFF);

        // R2 R3 R4: single set bit swept over bit positions and row index bits
        for (int p = -1; p < 10; p++) begin
            for (int b = 0; b < 8; b++) begin
                int pos;
                pos = (p < 0) ? 0 : ((p == 9) ? 511 : (1 << p));
                rearm();
                for (int i = 0; i < 512; i++) page[i] = 8'h00;
                page[pos][b] = 1'b1;
                feed(512, 1'b0);
                chk($sformatf("R2 R3 R4 single bit byte %0d bit %0d", pos, b), code_out, model(512));
            end
        end

        // R4 R6 R7: random pages with idle gaps, done edge, partial code
        for (int t = 0; t < 4; t++) begin
            rearm();
            for (int i = 0; i < 512; i++) page[i] = rnd();
            feed(300, 1'b1);
            chk("R6 partial page with gaps", code_out, model(300));
            for (int i = 300; i < 511; i++) push(page[i]);
            idle();
            chk("R7 done low after 511", {23'b0, done}, 24'h0);
            push(page[511]);
            idle();
            chk("R7 done after 512", {23'b0, done}, 24'h1);
            chk("R4 random page", code_out, model(512));
            // R8: extra bytes ignored
            for (int i = 0; i < 5; i++) push(8'h01 << i);
            idle();
            chk("R8 extra bytes ignored", code_out, model(512));
            chk("R7 done held", {23'b0, done}, 24'h1);
        end

        // R9: disarm mid page, strobes while disarmed, fresh page after
        rearm();
        for (int i = 0; i < 512; i++) page[i] = rnd();
        feed(100, 1'b0);
        chk("R9 mid page before clear", code_out, model(100));
        @(negedge clk); ecc_en = 1'b0;
        for (int i = 0; i < 4; i++) push(8'h80);
        idle();
        chk("R9 cleared code", code_out, 24'hFFFFFF);
        chk("R9 cleared done", {23'b0, done}, 24'h0);
        @(negedge clk); ecc_en = 1'b1;
        for (int i = 0; i < 512; i++) page[i] = rnd();
        feed(512, 1'b1);
        chk("R9 fresh page after rearm", code_out, model(512));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule